// File: doc/BRIEF.md
# SPI FIFO Register Front End

This block sits between a simple register bus and a serial shift engine. Software writes 32-bit words into a transmit queue and reads received data back from a receive queue. Both queues are counted in bytes. The serial engine takes transmit bytes one at a time and hands back received bytes one at a time. A transmit word is split into four bytes, and the byte in bits 31:24 goes out first. Received data can be read as a packed word or one byte at a time.

A status word gives two sticky events and both queue fill counts. The first event means room is left in the transmit queue. The second means receive data is waiting. An event bit is set while its condition holds and is cleared when software writes a one to it. A mask word picks which events drive the interrupt line. A control word holds the enable bit and the two thresholds that decide when each event is raised. When the enable bit is cleared, both queues are flushed and the engine is told to stop.

Top module: `spiFifoRegs`

## Requirements
- R1: After reset, the control word (address 0x00) reads 0x00000403: enable in bit 31 is 0, transmit threshold in bits 13:8 is 4, receive threshold in bits 5:0 is 3. The mask word (0x08) reads 0, and irq and engineEn are low.
- R2: A word written to address 0x10 while enabled pushes four bytes. The engine receives them in the order bits 31:24, 23:16, 15:8, 7:0.
- R3: A write to 0x10 is ignored as a whole when fewer than four bytes are free, or when the block is disabled.
- R4: A word read of 0x14 (regByte low) pops min(4, fill) bytes. The oldest byte is in bits 31:24, and lanes with no byte read as zero. A byte read (regByte high) pops one byte into bits 7:0. A read of an empty queue returns 0.
- R5: The event word (0x04) holds the receive fill in bytes in bits 29:24 and the transmit fill in bits 21:16. A byte offered by the engine when the receive queue already holds its 32 bytes is dropped.
- R6: Event bit 8 (transmit has room) is set in every cycle where the transmit fill is at or below the transmit threshold. Once set, it stays set until it is cleared.
- R7: Event bit 9 (receive data waiting) is set when the receive fill is above the receive threshold. It is also set after an xferEnd pulse if the receive queue is not empty.
- R8: A write to the event word clears each of bits 9:8 written as one. Bits written as zero are not changed.
- R9: irq is high exactly when some event bit is set whose bit in the mask word is also set. The mask holds bits 9:8 and reads back only those bits.
- R10: When the enable bit is cleared, both fills go to zero and engineEn drops.
- R11: A write to the control word changes the thresholds, and the event conditions use the new values.
- R12: txValid is high exactly when the transmit queue holds at least one byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| regWr | input | 1 | Register write strobe |
| regRd | input | 1 | Register read strobe; pops the receive queue at 0x14 |
| regByte | input | 1 | Read is one byte wide |
| regAddr | input | ADDR_W | Register byte address |
| regWdata | input | 32 | Write data |
| regRdata | output | 32 | Read data, valid in the cycle of regRd |
| irq | output | 1 | Masked event interrupt |
| engineEn | output | 1 | Enable to the serial engine |
| txValid | output | 1 | Transmit byte available |
| txByte | output | 8 | Oldest transmit byte |
| txTake | input | 1 | Engine consumes txByte |
| rxValid | input | 1 | Engine delivers rxByte |
| rxByte | input | 8 | Received byte |
| xferEnd | input | 1 | Pulse when a transaction ends |

## Verification
The transmit path is tested by filling the queue exactly to its limit and then offering one more word, so an off-by-one in the free-space check shows up. The queue is then drained through a scoreboard that compares the byte order. Receive reads use several fills — more than four, exactly one, empty, and full with extra pushes — which separates the packing, the zero-padding of empty lanes and the drop of bytes offered when full. The events are tested after the condition that set them has gone away, which shows the difference between sticky bits and live status. They are also tested after writes of zero and of one, after an end-of-transaction pulse, and under changed thresholds.

// File: rtl/spiFifoPkg.sv
package spiFifoPkg;
  localparam logic [7:0] ADDR_MODE = 8'h00;
  localparam logic [7:0] ADDR_EVT  = 8'h04;
  localparam logic [7:0] ADDR_MASK = 8'h08;
  localparam logic [7:0] ADDR_TX   = 8'h10;
  localparam logic [7:0] ADDR_RX   = 8'h14;
  localparam int BIT_EN = 31;
  localparam int BIT_NE = 9;
  localparam int BIT_NF = 8;
  localparam int FIELD_W = 6;

  typedef struct packed {
    logic       txPush;
    logic [2:0] rxPopCnt;
    logic       flush;
  } dpStrobe_t;
endpackage

// File: rtl/spiByteFifo.sv
module spiByteFifo #(
  parameter int DEPTH = 32,
  parameter int IN_LANES = 4,
  parameter int OUT_LANES = 1,
  localparam int PTR_W = $clog2(DEPTH),
  localparam int CNT_W = $clog2(DEPTH + 1),
  localparam int IN_W = $clog2(IN_LANES + 1),
  localparam int OUT_W = $clog2(OUT_LANES + 1)
) (
  input  logic                          clk,
  input  logic                          rstN,
  input  logic                          flush,
  input  logic [IN_W-1:0]               inCnt,
  input  logic [IN_LANES-1:0][7:0]      inData,
  input  logic [OUT_W-1:0]              outCnt,
  output logic [OUT_LANES-1:0][7:0]     outData,
  output logic [CNT_W-1:0]              fill
);
  logic [7:0] mem [DEPTH];
  logic [PTR_W-1:0] wrPtr, rdPtr;
  logic [CNT_W-1:0] count;

  always_ff @(posedge clk) begin
    for (int i = 0; i < IN_LANES; i++)
      if (!flush && (i < int'(inCnt))) mem[wrPtr + PTR_W'(i)] <= inData[i];
  end

  always_ff @(posedge clk) begin
    if (!rstN || flush) begin
      wrPtr <= '0;
      rdPtr <= '0;
      count <= '0;
    end else begin
      wrPtr <= wrPtr + PTR_W'(inCnt);
      rdPtr <= rdPtr + PTR_W'(outCnt);
      count <= count + CNT_W'(inCnt) - CNT_W'(outCnt);
    end
  end

  for (genvar g = 0; g < OUT_LANES; g++) begin : gPeek
    assign outData[g] = mem[rdPtr + PTR_W'(g)];
  end

  assign fill = count;

  assert_push_room_R3: assert property (@(posedge clk) disable iff (!rstN)
    (int'(inCnt) <= DEPTH - int'(count)));
  assert_pop_bound_R4: assert property (@(posedge clk) disable iff (!rstN)
    (int'(outCnt) <= int'(count)));
endmodule

// File: rtl/spiRegDatapath.sv
module spiRegDatapath
  import spiFifoPkg::*;
#(
  parameter int DEPTH = 32,
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rstN,
  input  dpStrobe_t        strobe,
  input  logic [31:0]      txWord,
  input  logic             txTake,
  input  logic             rxValid,
  input  logic [7:0]       rxByte,
  output logic             txValid,
  output logic [7:0]       txByte,
  output logic [CNT_W-1:0] txFill,
  output logic [CNT_W-1:0] rxFill,
  output logic [31:0]      rxPeek
);
  logic [3:0][7:0] txLanes;
  logic [3:0][7:0] rxLanes;
  logic [0:0][7:0] txHead;
  logic txPop, rxPush;

  for (genvar g = 0; g < 4; g++) begin : gLane
    assign txLanes[g] = txWord[31 - 8*g -: 8];
    assign rxPeek[31 - 8*g -: 8] = rxLanes[g];
  end

  assign txPop  = txTake && (txFill != '0) && !strobe.flush;
  assign rxPush = rxValid && (int'(rxFill) != DEPTH) && !strobe.flush;

  spiByteFifo #(.DEPTH(DEPTH), .IN_LANES(4), .OUT_LANES(1)) txQueue (
    .clk(clk), .rstN(rstN), .flush(strobe.flush),
    .inCnt(strobe.txPush ? 3'd4 : 3'd0), .inData(txLanes),
    .outCnt(txPop), .outData(txHead), .fill(txFill)
  );

  spiByteFifo #(.DEPTH(DEPTH), .IN_LANES(1), .OUT_LANES(4)) rxQueue (
    .clk(clk), .rstN(rstN), .flush(strobe.flush),
    .inCnt(rxPush), .inData(rxByte),
    .outCnt(strobe.rxPopCnt), .outData(rxLanes), .fill(rxFill)
  );

  assign txByte  = txHead[0];
  assign txValid = (txFill != '0);
endmodule

// File: rtl/spiRegCtrl.sv
module spiRegCtrl
  import spiFifoPkg::*;
#(
  parameter int DEPTH = 32,
  parameter int ADDR_W = 8,
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              regWr,
  input  logic              regRd,
  input  logic              regByte,
  input  logic [ADDR_W-1:0] regAddr,
  input  logic [31:0]       regWdata,
  output logic [31:0]       regRdata,
  input  logic [CNT_W-1:0]  txFill,
  input  logic [CNT_W-1:0]  rxFill,
  input  logic [31:0]       rxPeek,
  input  logic              xferEnd,
  output dpStrobe_t         strobe,
  output logic              irq,
  output logic              engineEn
);
  logic modeEn, maskNe, maskNf, evtNe, evtNf, endSeen;
  logic [FIELD_W-1:0] txThr, rxThr;
  logic isMode, isEvt, isMask, isTx, isRx;
  logic nfSet, neSet, rxAny;
  logic [2:0] popCnt;
  logic [31:0] rxWord, eventWord;

  assign isMode = (regAddr == ADDR_W'(ADDR_MODE));
  assign isEvt  = (regAddr == ADDR_W'(ADDR_EVT));
  assign isMask = (regAddr == ADDR_W'(ADDR_MASK));
  assign isTx   = (regAddr == ADDR_W'(ADDR_TX));
  assign isRx   = (regAddr == ADDR_W'(ADDR_RX));

  assign rxAny  = (rxFill != '0);
  assign popCnt = !(regRd && isRx) ? 3'd0 :
                  regByte ? {2'b00, rxAny} :
                  (int'(rxFill) >= 4) ? 3'd4 : 3'(rxFill);

  assign strobe.flush    = !modeEn;
  assign strobe.txPush   = regWr && isTx && modeEn && (DEPTH - int'(txFill) >= 4);
  assign strobe.rxPopCnt = popCnt;

  for (genvar k = 0; k < 4; k++) begin : gMask
    assign rxWord[31 - 8*k -: 8] = (k < int'(popCnt)) ? rxPeek[31 - 8*k -: 8] : 8'h00;
  end

  assign nfSet = (FIELD_W'(txFill) <= txThr);
  assign neSet = (FIELD_W'(rxFill) > rxThr) || (endSeen && rxAny);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      modeEn <= 1'b0;
      txThr <= FIELD_W'(4);
      rxThr <= FIELD_W'(3);
      maskNe <= 1'b0;
      maskNf <= 1'b0;
      evtNe <= 1'b0;
      evtNf <= 1'b0;
      endSeen <= 1'b0;
    end else begin
      if (regWr && isMode) begin
        modeEn <= regWdata[BIT_EN];
        txThr <= regWdata[8 +: FIELD_W];
        rxThr <= regWdata[0 +: FIELD_W];
      end
      if (regWr && isMask) begin
        maskNe <= regWdata[BIT_NE];
        maskNf <= regWdata[BIT_NF];
      end
      evtNf <= (evtNf && !(regWr && isEvt && regWdata[BIT_NF])) || nfSet;
      evtNe <= (evtNe && !(regWr && isEvt && regWdata[BIT_NE])) || neSet;
      if (!modeEn) endSeen <= 1'b0;
      else if (xferEnd) endSeen <= 1'b1;
      else if (!rxAny) endSeen <= 1'b0;
    end
  end

  assign eventWord = {2'b00, FIELD_W'(rxFill), 2'b00, FIELD_W'(txFill), 6'b0, evtNe, evtNf, 8'h00};

  always_comb begin
    regRdata = '0;
    if (isMode) regRdata = {modeEn, 17'b0, txThr, 2'b00, rxThr};
    else if (isEvt) regRdata = eventWord;
    else if (isMask) regRdata = {22'b0, maskNe, maskNf, 8'h00};
    else if (isRx) regRdata = regByte ? {24'b0, (rxAny ? rxPeek[31:24] : 8'h00)} : rxWord;
  end

  assign irq = (evtNe && maskNe) || (evtNf && maskNf);
  assign engineEn = modeEn;

  assert_flush_R10: assert property (@(posedge clk) disable iff (!rstN)
    !modeEn |=> (txFill == '0) && (rxFill == '0));
  assert_tx_drop_R3: assert property (@(posedge clk) disable iff (!rstN)
    (regWr && isTx && (!modeEn || (DEPTH - int'(txFill) < 4))) |=> (txFill <= $past(txFill)));
  assert_ne_clear_R8: assert property (@(posedge clk) disable iff (!rstN)
    (regWr && isEvt && regWdata[BIT_NE] && !neSet) |=> !evtNe);
endmodule

// File: rtl/spiFifoRegs.sv
module spiFifoRegs
  import spiFifoPkg::*;
#(
  parameter int DEPTH = 32,
  parameter int ADDR_W = 8,
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              regWr,
  input  logic              regRd,
  input  logic              regByte,
  input  logic [ADDR_W-1:0] regAddr,
  input  logic [31:0]       regWdata,
  output logic [31:0]       regRdata,
  output logic              irq,
  output logic              engineEn,
  output logic              txValid,
  output logic [7:0]        txByte,
  input  logic              txTake,
  input  logic              rxValid,
  input  logic [7:0]        rxByte,
  input  logic              xferEnd
);
  dpStrobe_t strobe;
  logic [CNT_W-1:0] txFill, rxFill;
  logic [31:0] rxPeek;

  spiRegCtrl #(.DEPTH(DEPTH), .ADDR_W(ADDR_W)) ctrl (
    .clk(clk), .rstN(rstN), .regWr(regWr), .regRd(regRd), .regByte(regByte),
    .regAddr(regAddr), .regWdata(regWdata), .regRdata(regRdata),
    .txFill(txFill), .rxFill(rxFill), .rxPeek(rxPeek), .xferEnd(xferEnd),
    .strobe(strobe), .irq(irq), .engineEn(engineEn)
  );

  spiRegDatapath #(.DEPTH(DEPTH)) dp (
    .clk(clk), .rstN(rstN), .strobe(strobe), .txWord(regWdata),
    .txTake(txTake), .rxValid(rxValid), .rxByte(rxByte),
    .txValid(txValid), .txByte(txByte), .txFill(txFill), .rxFill(rxFill),
    .rxPeek(rxPeek)
  );
endmodule

// File: tb/spiFifoRegs_test.sv
module spiFifoRegs_test;
  logic clk = 1'b0, rstN = 1'b0;
  logic regWr = 0, regRd = 0, regByte = 0;
  logic [7:0] regAddr = 0;
  logic [31:0] regWdata = 0, regRdata;
  logic irq, engineEn, txValid, txTake = 0, rxValid = 0, xferEnd = 0;
  logic [7:0] txByte, rxByte = 0;
  int checks = 0, errors = 0;
  bit drainOn = 0, done = 0;
  logic [7:0] expQ[$];
  logic [7:0] rxQ[$];

  always #10 clk = ~clk;

  spiFifoRegs uut (.clk(clk), .rstN(rstN), .regWr(regWr), .regRd(regRd), .regByte(regByte),
    .regAddr(regAddr), .regWdata(regWdata), .regRdata(regRdata), .irq(irq),
    .engineEn(engineEn), .txValid(txValid), .txByte(txByte), .txTake(txTake),
    .rxValid(rxValid), .rxByte(rxByte), .xferEnd(xferEnd));

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  // Monitor: scoreboard for the transmit byte stream (R2)
  always @(negedge clk) begin
    if (drainOn && txValid) begin
      if (expQ.size() == 0) check("R2 unexpected byte", {24'b0, txByte}, 32'hxxxxxxxx);
      else check("R2 byte order", {24'b0, txByte}, {24'b0, expQ.pop_front()});
      txTake = 1'b1;
    end else txTake = 1'b0;
  end

  task automatic idle(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wrReg(logic [7:0] a, logic [31:0] d);
    @(negedge clk);
    regWr = 1; regAddr = a; regWdata = d;
    @(negedge clk);
    regWr = 0;
  endtask

  task automatic rdReg(logic [7:0] a, bit byteWide, output logic [31:0] d);
    @(negedge clk);
    regRd = 1; regAddr = a; regByte = byteWide;
    #1 d = regRdata;
    @(negedge clk);
    regRd = 0; regByte = 0;
  endtask

  task automatic txWrite(logic [31:0] d, bit accept);
    wrReg(8'h10, d);
    if (accept) for (int i = 3; i >= 0; i--) expQ.push_back(d[8*i +: 8]);
  endtask

  task automatic pushRx(logic [7:0] b);
    @(negedge clk);
    rxValid = 1; rxByte = b;
    @(negedge clk);
    rxValid = 0;
    if (rxQ.size() < 32) rxQ.push_back(b);
  endtask

  task automatic checkRead(string req, bit byteWide);
    logic [31:0] d, e;
    e = 0;
    if (byteWide) begin
      if (rxQ.size() > 0) e = {24'b0, rxQ.pop_front()};
    end else
      for (int i = 3; i >= 0; i--) if (rxQ.size() > 0) e[8*i +: 8] = rxQ.pop_front();
    rdReg(8'h14, byteWide, d);
    check(req, d, e);
  endtask

  task automatic checkEvt(string req, logic [31:0] e);
    logic [31:0] d;
    idle(2);
    rdReg(8'h04, 0, d);
    check(req, d, e);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [31:0] d;
    idle(3);
    rstN = 1;
    // R1 reset state
    rdReg(8'h00, 0, d); check("R1 mode reset", d, 32'h0000_0403);
    rdReg(8'h08, 0, d); check("R1 mask reset", d, 32'h0);
    check("R1 irq/engineEn", {irq, engineEn}, 2'b00);
    checkEvt("R6 idle NF", 32'h0000_0100);
    // enable
    wrReg(8'h00, 32'h8000_0403);
    check("R10 engineEn on", engineEn, 1);
    check("R12 txValid empty", txValid, 0);
    txWrite(32'h1122_3344, 1);
    txWrite(32'h5566_7788, 1);
    check("R12 txValid filled", txValid, 1);
    checkEvt("R5 tx fill 8", 32'h0008_0100);
    wrReg(8'h04, 32'h0);
    checkEvt("R8 zero write no effect", 32'h0008_0100);
    wrReg(8'h04, 32'h0000_0100);
    checkEvt("R8 clear NF / R6 sticky", 32'h0008_0000);
    for (int k = 1; k <= 6; k++) txWrite(32'h0101_0101 * k, 1);
    checkEvt("R5 tx full", 32'h0020_0000);
    txWrite(32'hDEAD_BEEF, 0);
    checkEvt("R3 write when full ignored", 32'h0020_0000);
    drainOn = 1;
    wait (!txValid);
    idle(3);
    drainOn = 0;
    check("R2 all bytes drained", expQ.size(), 0);
    checkEvt("R6 NF after drain", 32'h0000_0100);
    // receive path
    for (int i = 0; i < 5; i++) pushRx(8'hA0 + 8'(i));
    checkEvt("R5 R7 rx fill 5", 32'h0500_0300);
    check("R9 irq masked off", irq, 0);
    checkRead("R4 word read", 0);
    checkEvt("R7 NE sticky", 32'h0100_0300);
    wrReg(8'h04, 32'h0000_0200);
    checkEvt("R8 clear NE", 32'h0100_0100);
    @(negedge clk); xferEnd = 1; @(negedge clk); xferEnd = 0;
    checkEvt("R7 NE after end", 32'h0100_0300);
    checkRead("R4 partial word", 0);
    checkRead("R4 empty byte read", 1);
    wrReg(8'h04, 32'h0000_0200);
    checkEvt("R7 NE clear empty", 32'h0000_0100);
    pushRx(8'hB0); pushRx(8'hB1);
    checkRead("R4 byte read 0", 1);
    checkRead("R4 byte read 1", 1);
    // interrupt masking
    wrReg(8'h08, 32'hFFFF_FFFF);
    rdReg(8'h08, 0, d); check("R9 mask readback", d, 32'h0000_0300);
    wrReg(8'h08, 32'h0000_0200);
    idle(1); check("R9 irq NE masked clear", irq, 0);
    for (int i = 0; i < 4; i++) pushRx(8'hC0 + 8'(i));
    idle(2); check("R9 irq on NE", irq, 1);
    wrReg(8'h08, 32'h0000_0100);
    idle(1); check("R9 irq on NF", irq, 1);
    wrReg(8'h08, 32'h0);
    idle(1); check("R9 irq mask off", irq, 0);
    // thresholds
    wrReg(8'h00, 32'h8000_0205);
    rdReg(8'h00, 0, d); check("R11 mode readback", d, 32'h8000_0205);
    wrReg(8'h04, 32'h0000_0200);
    checkEvt("R11 rx thr 5 not met", 32'h0400_0100);
    pushRx(8'hD0); pushRx(8'hD1);
    checkEvt("R11 rx thr 5 exceeded", 32'h0600_0300);
    txWrite(32'hCAFE_F00D, 1);
    wrReg(8'h04, 32'h0000_0100);
    checkEvt("R11 tx thr 2", 32'h0604_0200);
    // flush
    wrReg(8'h00, 32'h0000_0205);
    expQ.delete(); rxQ.delete();
    checkEvt("R10 flush", 32'h0000_0300);
    check("R10 engineEn off", {engineEn, txValid}, 2'b00);
    wrReg(8'h10, 32'h1234_5678);
    checkEvt("R3 write disabled ignored", 32'h0000_0300);
    // receive overflow
    wrReg(8'h00, 32'h8000_0403);
    wrReg(8'h04, 32'h0000_0300);
    for (int i = 0; i < 34; i++) pushRx(8'hE0 + 8'(i));
    checkEvt("R5 rx full drop", 32'h2000_0300);
    checkRead("R5 first bytes kept", 0);
    done = 1;
    $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule